// File: doc/BRIEF.md
# Breakpoint Trigger Selector with Scan Configuration

This block turns two internal condition flags into one breakpoint pin that can halt a processor clock. One flag comes from a detector watching a converted analog value. The other comes from a detector watching a digital word. An 8-bit configuration register sits on the test scan path. It carries an operation code for each detector and a 2-bit field that picks how the two flags are combined: digital only, analog only, either, or both.

The pin is registered on TCK. It can only be high when two things hold at the same edge: a detection-class instruction is loaded, and the test controller reports its idle run state. The block also gates the data-register update strobe that goes to the detectors' update stages. While a detection instruction is active, that strobe is held off, so the limit values already stored there are kept.

Top module: `trig_cfg_sel`

## Requirements
- R1: When `trst_n` is low, the shift stage, the held configuration and `trig` all go to zero, so `op_dig`, `op_ana`, `tdo_cfg` and `trig` read 0.
- R2: The held select field (bits [1:0]) sets the raw trigger as follows: 00 gives `flag_dig`, 01 gives `flag_ana`, 10 gives `flag_dig | flag_ana`, and 11 gives `flag_dig & flag_ana`.
- R3: `trig` is high only if `tap_state` equalled the idle code `RTI_CODE` (4'hC by default) at the preceding TCK rising edge. Any other code, including 4'hD, forces it low.
- R4: `trig` is high only if `det_insn` was high at the preceding TCK rising edge.
- R5: The held configuration has this layout: bits [7:5] drive `op_dig`, bits [4:2] drive `op_ana`, and bits [1:0] are the select field. It takes the shift-stage value only at a TCK rising edge where both `cfg_sel` and `update_dr` are high. Otherwise, including an update without `cfg_sel`, it does not change. Loading 8'b01101010 gives `op_dig`=3'b011, `op_ana`=3'b010 and select 10.
- R6: At a TCK rising edge with both `cfg_sel` and `shift_dr` high, the shift stage moves one place toward bit 0 and `tdi` enters bit 7. `tdo_cfg` always shows bit 0, so the first bit shifted in ends up in bit 0. Shifting never changes `op_dig` or `op_ana`.
- R7: `det_update` follows `update_dr` when `det_insn` is low, and is held low while `det_insn` is high.
- R8: `trig` is a register. A change on the flags or the qualifiers shows on `trig` only after the next TCK rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial data in |
| cfg_sel | input | 1 | Configuration-select instruction is loaded |
| shift_dr | input | 1 | Controller is in the data shift state |
| update_dr | input | 1 | Controller is in the data update state |
| det_insn | input | 1 | Detection-class instruction is loaded |
| tap_state | input | ST_W | Encoded controller state |
| flag_dig | input | 1 | Digital detector condition flag |
| flag_ana | input | 1 | Analog detector condition flag |
| tdo_cfg | output | 1 | Serial data out of the configuration register |
| op_dig | output | OP_W | Operation code for the digital detector |
| op_ana | output | OP_W | Operation code for the analog detector |
| det_update | output | 1 | Gated update strobe to the detectors' update stages |
| trig | output | 1 | Registered breakpoint output |

## Verification
The bench uses the default parameters: a 4-bit state code with idle at 4'hC, and 3-bit operation codes. With these values a full reconfiguration takes only eight shift clocks. That makes it cheap to rescan the register before every vector, so each select code is reached through the scan path and not forced. The 4-bit state width also allows a near-miss code (4'hD) next to the idle code, which probes the exact state match.

// File: rtl/trig_cfg_sel.sv
module trig_cfg_sel #(
  parameter int ST_W = 4,
  parameter logic [ST_W-1:0] RTI_CODE = 4'hC,
  parameter int OP_W = 3
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  logic            cfg_sel,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic            det_insn,
  input  logic [ST_W-1:0] tap_state,
  input  logic            flag_dig,
  input  logic            flag_ana,
  output logic            tdo_cfg,
  output logic [OP_W-1:0] op_dig,
  output logic [OP_W-1:0] op_ana,
  output logic            det_update,
  output logic            trig
);
  localparam int SEL_W = 2;
  localparam int CFG_W = 2*OP_W + SEL_W;

  logic [CFG_W-1:0] sh_q, cfg_q;
  logic [SEL_W-1:0] sel;
  logic             hit;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)                sh_q <= '0;
    else if (cfg_sel && shift_dr) sh_q <= {tdi, sh_q[CFG_W-1:1]};

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)                 cfg_q <= '0;
    else if (cfg_sel && update_dr) cfg_q <= sh_q;

  assign tdo_cfg = sh_q[0];
  assign op_dig  = cfg_q[CFG_W-1 -: OP_W];
  assign op_ana  = cfg_q[SEL_W +: OP_W];
  assign sel     = cfg_q[SEL_W-1:0];

  always_comb
    case (sel)
      2'b00:   hit = flag_dig;
      2'b01:   hit = flag_ana;
      2'b10:   hit = flag_dig | flag_ana;
      default: hit = flag_dig & flag_ana;
    endcase

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) trig <= 1'b0;
    else         trig <= hit && det_insn && (tap_state == RTI_CODE);

  assign det_update = update_dr & ~det_insn;
endmodule

// File: rtl/trig_cfg_sel_chk.sv
module trig_cfg_sel_chk #(
  parameter int ST_W = 4,
  parameter logic [ST_W-1:0] RTI_CODE = 4'hC,
  parameter int OP_W = 3
) (
  input logic            tck,
  input logic            trst_n,
  input logic            trig,
  input logic            det_insn,
  input logic [ST_W-1:0] tap_state,
  input logic            flag_dig,
  input logic            flag_ana,
  input logic [1:0]      sel,
  input logic            cfg_sel,
  input logic            shift_dr,
  input logic            update_dr,
  input logic [OP_W-1:0] op_dig,
  input logic [OP_W-1:0] op_ana
);
  p_idle_only_r3: assert property (@(posedge tck) disable iff (!trst_n)
    trig |-> $past(tap_state) == RTI_CODE);

  p_det_only_r4: assert property (@(posedge tck) disable iff (!trst_n)
    trig |-> $past(det_insn));

  p_or_mode_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (trig && $past(sel) == 2'b10) |-> $past(flag_dig || flag_ana));

  p_and_mode_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (trig && $past(sel) == 2'b11) |-> $past(flag_dig && flag_ana));

  p_cfg_hold_r5: assert property (@(posedge tck) disable iff (!trst_n)
    !(cfg_sel && update_dr) |=> $stable({op_dig, op_ana}));

  p_shift_no_ops_r6: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_dr && !update_dr) |=> $stable({op_dig, op_ana}));
endmodule

bind trig_cfg_sel trig_cfg_sel_chk #(.ST_W(ST_W), .RTI_CODE(RTI_CODE), .OP_W(OP_W)) u_chk (
  .tck(tck), .trst_n(trst_n), .trig(trig), .det_insn(det_insn),
  .tap_state(tap_state), .flag_dig(flag_dig), .flag_ana(flag_ana),
  .sel(cfg_q[1:0]), .cfg_sel(cfg_sel), .shift_dr(shift_dr),
  .update_dr(update_dr), .op_dig(op_dig), .op_ana(op_ana)
);

// File: tb/trig_cfg_sel_bench.sv
module trig_cfg_sel_bench;
  logic tck = 1'b0, trst_n = 1'b0, tdi = 1'b0, cfg_sel = 1'b0, shift_dr = 1'b0;
  logic update_dr = 1'b0, det_insn = 1'b0, flag_dig = 1'b0, flag_ana = 1'b0;
  logic [3:0] tap_state = 4'h0;
  logic tdo_cfg, det_update, trig;
  logic [2:0] op_dig, op_ana;
  int n_chk = 0, n_bad = 0;

  always #5 tck = ~tck;

  trig_cfg_sel u_trig_cfg_sel (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .cfg_sel(cfg_sel), .shift_dr(shift_dr),
    .update_dr(update_dr), .det_insn(det_insn), .tap_state(tap_state),
    .flag_dig(flag_dig), .flag_ana(flag_ana), .tdo_cfg(tdo_cfg), .op_dig(op_dig),
    .op_ana(op_ana), .det_update(det_update), .trig(trig));

  // {cfg[7:0], det_insn, tap_state[3:0], flag_dig, flag_ana, expected trig}
  localparam logic [15:0] VEC [12] = '{
    {8'h68, 1'b1, 4'hC, 1'b1, 1'b0, 1'b1},
    {8'h68, 1'b1, 4'hC, 1'b0, 1'b1, 1'b0},
    {8'h69, 1'b1, 4'hC, 1'b0, 1'b1, 1'b1},
    {8'h69, 1'b1, 4'hC, 1'b1, 1'b0, 1'b0},
    {8'h6A, 1'b1, 4'hC, 1'b1, 1'b0, 1'b1},
    {8'h6A, 1'b1, 4'hC, 1'b0, 1'b1, 1'b1},
    {8'h6A, 1'b1, 4'hC, 1'b0, 1'b0, 1'b0},
    {8'h6B, 1'b1, 4'hC, 1'b1, 1'b1, 1'b1},
    {8'h6B, 1'b1, 4'hC, 1'b1, 1'b0, 1'b0},
    {8'h6A, 1'b1, 4'h1, 1'b1, 1'b1, 1'b0},
    {8'h6A, 1'b0, 4'hC, 1'b1, 1'b1, 1'b0},
    {8'h6B, 1'b1, 4'hD, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic scan_in(input logic [7:0] v, input logic do_update);
    @(negedge tck);
    cfg_sel = 1'b1; shift_dr = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tdi = v[i];
      @(negedge tck);
    end
    shift_dr = 1'b0;
    update_dr = do_update;
    @(negedge tck);
    update_dr = 1'b0; cfg_sel = 1'b0;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge tck);
    check("R1 trig", {7'd0, trig}, 8'd0);
    check("R1 ops", {2'd0, op_dig, op_ana}, 8'd0);
    check("R1 tdo", {7'd0, tdo_cfg}, 8'd0);
    trst_n = 1'b1;

    for (int k = 0; k < 12; k++) begin
      scan_in(VEC[k][15:8], 1'b1);
      det_insn = VEC[k][7]; tap_state = VEC[k][6:3];
      flag_dig = VEC[k][2]; flag_ana = VEC[k][1];
      @(negedge tck);
      check($sformatf("R2/R3/R4 vec %0d", k), {7'd0, trig}, {7'd0, VEC[k][0]});
      det_insn = 1'b0; flag_dig = 1'b0; flag_ana = 1'b0; tap_state = 4'h0;
      @(negedge tck);
    end

    scan_in(8'b01101010, 1'b1);
    check("R5 op_dig", {5'd0, op_dig}, 8'd3);
    check("R5 op_ana", {5'd0, op_ana}, 8'd2);

    scan_in(8'b10100101, 1'b0);
    check("R6 shift keeps ops", {2'd0, op_dig, op_ana}, {2'd0, 3'b011, 3'b010});
    @(negedge tck);
    update_dr = 1'b1;
    @(negedge tck);
    update_dr = 1'b0;
    check("R5 update without select", {2'd0, op_dig, op_ana}, {2'd0, 3'b011, 3'b010});

    cfg_sel = 1'b1; shift_dr = 1'b1; tdi = 1'b0;
    for (int i = 0; i < 8; i++) begin
      check($sformatf("R6 tdo bit %0d", i), {7'd0, tdo_cfg}, {7'd0, 8'b10100101 >> i & 8'd1});
      @(negedge tck);
    end
    shift_dr = 1'b0; cfg_sel = 1'b0;

    det_insn = 1'b0; update_dr = 1'b1; #1;
    check("R7 pass", {7'd0, det_update}, 8'd1);
    det_insn = 1'b1; #1;
    check("R7 block", {7'd0, det_update}, 8'd0);
    update_dr = 1'b0;
    @(negedge tck);

    tap_state = 4'hC; flag_dig = 1'b1; #1;
    check("R8 before edge", {7'd0, trig}, 8'd0);
    @(negedge tck);
    check("R8 after edge", {7'd0, trig}, 8'd1);
    tap_state = 4'h1;
    @(negedge tck);
    check("R3 leave idle", {7'd0, trig}, 8'd0);

    trst_n = 1'b0; #1;
    check("R1 reset ops", {2'd0, op_dig, op_ana}, 8'd0);
    trst_n = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule